// File: doc/BRIEF.md
# Isochronous OUT Endpoint Ping-Pong Packet Store

This block is the receive-side packet store for one isochronous OUT endpoint of a USB device controller. The serial interface engine hands it a byte stream framed by start and end strobes. The block writes each packet into one of two 128-byte slots, and the two slots are used in turn. When a packet has been taken in completely, the block raises an interrupt request and a DMA request. The local processor or a DMA engine then drains the packet one byte at a time through a read-only 8-bit data port.

While the reader is still emptying one slot and the other slot already holds a finished packet, every OUT token from the host gets a NAK decision. That decision is held until a whole slot is free again. Reading only part of a packet does not release the slot. Packets reach the reader in the order they arrived. An oversize packet is cut to the slot size and flagged. An aborted packet or a zero-length packet leaves nothing behind.

Top module: `iso_out_pingpong`

## Requirements
- R1: After a synchronous reset, `irq` and `dma_req` are 0, `rd_valid` is 0 and `rd_data` is 0. An OUT token gives `out_nak` = 0, and the first packet received afterwards is the first packet read out.
- R2: The bytes of a stored packet appear on `rd_data[7:0]` in the order they were received. `rd_data` shows the head byte, and each cycle with `rd_en` high and `rd_valid` high moves to the next byte.
- R3: The cycle after the `rx_eop` strobe of a non-empty packet, `irq` and `dma_req` are 1. They stay at 1 while either slot holds an undrained packet and drop to 0 once both slots are empty.
- R4: `rd_last` is 1 exactly on the final byte of the packet. Once that byte is consumed, the slot is freed and the reader moves on to the other slot. Packets are delivered in arrival order.
- R5: When both slots hold packets, an `out_tok` pulse gives `out_nak` = 1 in the same cycle.
- R6: NAK stays in force while the reader has consumed only some of the bytes of the older packet. It clears in the cycle after the last byte of that packet is consumed.
- R7: In a packet longer than 128 bytes, the bytes beyond 128 are dropped and the stored packet is 128 bytes long. `rx_ovf` is 1 from the first dropped byte until the next accepted `rx_sop`.
- R8: An `rx_abort` before `rx_eop` leaves the slot empty and raises no request. The next packet uses that same slot.
- R9: A packet with `rx_eop` but no data bytes is discarded: `irq` stays 0 and `rd_valid` stays 0.
- R10: `rd_en` while `rd_valid` is 0 has no effect. `rd_data` stays 0, and a packet stored later is read out from its first byte.
- R11: A packet that starts while the slot it would be written into is still full is ignored entirely. The stored packets are read back unchanged and nothing extra is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sop | input | 1 | Start-of-packet strobe (carries no data) |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_eop | input | 1 | End-of-packet strobe (carries no data) |
| rx_abort | input | 1 | Discard the packet in progress |
| rx_ovf | output | 1 | Current or last packet exceeded slot size |
| out_tok | input | 1 | OUT token arrival strobe |
| out_nak | output | 1 | NAK decision for the token in this cycle |
| rd_en | input | 1 | Consume the head byte |
| rd_data | output | 8 | Head byte of the packet being read, 0 when none |
| rd_valid | output | 1 | A completed packet is available |
| rd_last | output | 1 | Head byte is the final byte of its packet |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench fills both slots and then reads the older packet only partly. A design that released the slot on the first read, or that derived NAK from free byte space, would drop NAK too early at that point. Delivery order is checked across the wrap from slot 1 back to slot 0, which catches a reader selector that failed to alternate or stayed stuck. A 130-byte packet checks that the truncated packet ends with `rd_last` on byte 128, so a length counter one bit too narrow shows up as a wrong last flag. Aborted packets, empty packets, packets that start while both slots are full, and stray reads on an empty store are each followed by a real packet. That packet must arrive whole and first-byte-first, which exposes leaked state.

// File: rtl/iso_out_pkg.sv
package iso_out_pkg;

    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_FILLING = 2'd1,
        SLOT_FULL    = 2'd2
    } slot_state_e;

    typedef struct packed {
        logic start;
        logic commit;
        logic drop;
    } slot_cmd_t;

    function automatic logic is_full(input slot_state_e s);
        return s == SLOT_FULL;
    endfunction

endpackage

// File: rtl/iso_slot_state.sv
module iso_slot_state
    import iso_out_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_cmd_t        cmd,
    input  logic [LEN_W-1:0] commit_len,
    input  logic             release_i,
    output slot_state_e      state_o,
    output logic [LEN_W-1:0] len_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o <= SLOT_EMPTY;
            len_o   <= '0;
        end else if (release_i) begin
            state_o <= SLOT_EMPTY;
        end else if (cmd.drop) begin
            state_o <= SLOT_EMPTY;
        end else if (cmd.commit) begin
            state_o <= SLOT_FULL;
            len_o   <= commit_len;
        end else if (cmd.start) begin
            state_o <= SLOT_FILLING;
        end
    end

    // R4: only a full slot can be released by the reader
    p_release_only_full_r4: assert property (@(posedge clk) disable iff (rst)
        release_i |-> state_o == SLOT_FULL);

    // R3: a packet is only committed out of the filling state
    p_commit_from_filling_r3: assert property (@(posedge clk) disable iff (rst)
        cmd.commit |-> state_o == SLOT_FILLING);

endmodule

// File: rtl/iso_pkt_mem.sv
module iso_pkt_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/iso_wr_ctrl.sv
module iso_wr_ctrl
    import iso_out_pkg::*;
#(
    parameter int SLOT_BYTES = 128,
    localparam int ADDR_W    = $clog2(SLOT_BYTES),
    localparam int LEN_W     = $clog2(SLOT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sop,
    input  logic              valid,
    input  logic              eop,
    input  logic              abort,
    input  slot_state_e       tgt_state,
    output logic              wr_sel,
    output slot_cmd_t         cmd,
    output logic [LEN_W-1:0]  wr_len,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic              ovf
);

    logic [LEN_W-1:0] wr_ptr;
    logic             filling;
    logic             at_cap;

    assign filling = (tgt_state == SLOT_FILLING);
    assign at_cap  = (wr_ptr == LEN_W'(SLOT_BYTES));

    always_comb begin
        cmd.drop   = filling && (abort || (eop && wr_ptr == '0));
        cmd.commit = filling && eop && !abort && (wr_ptr != '0);
        cmd.start  = sop && !eop && !abort && !is_full(tgt_state);
    end

    assign we     = valid && filling && !at_cap && !cmd.start;
    assign waddr  = wr_ptr[ADDR_W-1:0];
    assign wr_len = wr_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            wr_sel <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            if (cmd.start) begin
                wr_ptr <= '0;
                ovf    <= 1'b0;
            end else if (we) begin
                wr_ptr <= wr_ptr + 1'b1;
            end else if (valid && filling && at_cap) begin
                ovf <= 1'b1;
            end
            if (cmd.commit) wr_sel <= ~wr_sel;
        end
    end

    // R7: the write pointer never passes the slot size
    p_wrptr_capped_r7: assert property (@(posedge clk) disable iff (rst)
        wr_ptr <= LEN_W'(SLOT_BYTES));

    // R11: no byte is written into a slot that holds a finished packet
    p_no_write_full_r11: assert property (@(posedge clk) disable iff (rst)
        is_full(tgt_state) |-> !we);

endmodule

// File: rtl/iso_rd_ctrl.sv
module iso_rd_ctrl
    import iso_out_pkg::*;
#(
    parameter int SLOT_BYTES = 128,
    localparam int ADDR_W    = $clog2(SLOT_BYTES),
    localparam int LEN_W     = $clog2(SLOT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  slot_state_e       cur_state,
    input  logic [LEN_W-1:0]  cur_len,
    output logic              rd_sel,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic              ready,
    output logic              last,
    output logic              release_o
);

    assign ready     = is_full(cur_state);
    assign last      = ready && (LEN_W'(rd_ptr) == cur_len - 1'b1);
    assign release_o = rd_en && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_sel <= 1'b0;
            rd_ptr <= '0;
        end else if (rd_en && ready) begin
            if (last) begin
                rd_ptr <= '0;
                rd_sel <= ~rd_sel;
            end else begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    // R4: the read pointer stays inside the stored packet
    p_rdptr_in_packet_r4: assert property (@(posedge clk) disable iff (rst)
        ready |-> LEN_W'(rd_ptr) < cur_len);

    // R10: reads with nothing ready leave the pointer alone
    p_idle_read_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !ready) |=> $stable(rd_ptr));

endmodule

// File: rtl/iso_out_pingpong.sv
module iso_out_pingpong
    import iso_out_pkg::*;
#(
    parameter int SLOT_BYTES = 128,
    parameter int DATA_W     = 8,
    localparam int NSLOT     = 2,
    localparam int ADDR_W    = $clog2(SLOT_BYTES),
    localparam int LEN_W     = $clog2(SLOT_BYTES + 1),
    localparam int MEM_AW    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_sop,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_eop,
    input  logic              rx_abort,
    output logic              rx_ovf,
    input  logic              out_tok,
    output logic              out_nak,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_last,
    output logic              irq,
    output logic              dma_req
);

    slot_state_e      st  [NSLOT];
    logic [LEN_W-1:0] len [NSLOT];

    logic              wr_sel, rd_sel, we, rel;
    slot_cmd_t         wcmd;
    logic [LEN_W-1:0]  wlen;
    logic [ADDR_W-1:0] waddr, rptr;
    logic [DATA_W-1:0] mem_q;

    iso_wr_ctrl #(.SLOT_BYTES(SLOT_BYTES)) u_wr (
        .clk(clk), .rst(rst), .sop(rx_sop), .valid(rx_valid), .eop(rx_eop),
        .abort(rx_abort), .tgt_state(st[wr_sel]), .wr_sel(wr_sel), .cmd(wcmd),
        .wr_len(wlen), .we(we), .waddr(waddr), .ovf(rx_ovf)
    );

    iso_rd_ctrl #(.SLOT_BYTES(SLOT_BYTES)) u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .cur_state(st[rd_sel]),
        .cur_len(len[rd_sel]), .rd_sel(rd_sel), .rd_ptr(rptr),
        .ready(rd_valid), .last(rd_last), .release_o(rel)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        slot_cmd_t scmd;
        assign scmd = (wr_sel == 1'(s)) ? wcmd : '0;
        iso_slot_state #(.LEN_W(LEN_W)) u_state (
            .clk(clk), .rst(rst), .cmd(scmd), .commit_len(wlen),
            .release_i(rel && (rd_sel == 1'(s))),
            .state_o(st[s]), .len_o(len[s])
        );
    end

    iso_pkt_mem #(.DATA_W(DATA_W), .DEPTH(NSLOT * SLOT_BYTES)) u_mem (
        .clk(clk), .we(we), .waddr({wr_sel, waddr}), .wdata(rx_data),
        .raddr({rd_sel, rptr}), .rdata(mem_q)
    );

    assign rd_data = rd_valid ? mem_q : '0;
    assign out_nak = out_tok && is_full(st[wr_sel]);
    assign irq     = is_full(st[0]) || is_full(st[1]);
    assign dma_req = irq;

    // R5: a NAK is only given while a packet is waiting for the reader
    p_nak_needs_backlog_r5: assert property (@(posedge clk) disable iff (rst)
        out_nak |-> rd_valid);

    // R3: requests only rise right after an end-of-packet
    p_req_rises_on_eop_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(rx_eop));

    // R6: a NAK while reading the older packet persists until its last byte goes
    p_nak_held_r6: assert property (@(posedge clk) disable iff (rst)
        (out_tok && out_nak && !rel && out_tok) |=> (out_tok -> out_nak));

endmodule

// File: tb/tb_iso_out_pingpong.sv
module tb_iso_out_pingpong;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_sop = 0, rx_valid = 0, rx_eop = 0, rx_abort = 0;
    logic [7:0] rx_data = 0;
    logic       out_tok = 0, rd_en = 0;
    logic       rx_ovf, out_nak, rd_valid, rd_last, irq, dma_req;
    logic [7:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [7:0] exp_q [$];

    always #2 clk = ~clk;

    iso_out_pingpong dut (
        .clk(clk), .rst(rst), .rx_sop(rx_sop), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_eop(rx_eop), .rx_abort(rx_abort),
        .rx_ovf(rx_ovf), .out_tok(out_tok), .out_nak(out_nak),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_last(rd_last), .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input int act, input int exp, input string req);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // driver: pushes the bytes the reader should see into the scoreboard
    task automatic send(input int n, input int seed, input bit keep);
        @(negedge clk); rx_sop = 1;
        @(negedge clk); rx_sop = 0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_data = 8'(seed + i * 7);
            if (keep && i < 128) exp_q.push_back(rx_data);
            @(negedge clk);
        end
        rx_valid = 0; rx_eop = 1;
        @(negedge clk); rx_eop = 0;
    endtask

    // monitor: pops the scoreboard while draining
    task automatic drain(input int cnt, input int remain);
        for (int i = 0; i < cnt; i++) begin
            logic [7:0] e;
            @(negedge clk);
            e = exp_q.pop_front();
            chk(rd_valid, 1, "R2 valid");
            chk(rd_data, e, "R2 data");
            chk(rd_last, (i == remain - 1), "R4 last");
            rd_en = 1;
        end
        @(negedge clk); rd_en = 0;
    endtask

    task automatic token(input int exp, input string req);
        out_tok = 1; #1;
        chk(out_nak, exp, req);
        out_tok = 0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(irq, 0, "R1 irq"); chk(dma_req, 0, "R1 dma");
        chk(rd_valid, 0, "R1 valid"); chk(rd_data, 0, "R1 data");
        token(0, "R1 nak");

        // R3 request after eop, R2/R4 single packet
        send(5, 16, 1);
        chk(irq, 1, "R3 irq"); chk(dma_req, 1, "R3 dma");
        drain(5, 5);
        chk(irq, 0, "R3 irq clear"); chk(rd_valid, 0, "R4 freed");

        // R5/R6 both full, partial drain, order across wrap
        send(4, 40, 1);
        send(6, 90, 1);
        token(1, "R5 nak");
        drain(2, 4);
        token(1, "R6 nak held");
        drain(2, 2);
        token(0, "R6 nak cleared");
        chk(irq, 1, "R3 irq held");
        drain(6, 6);
        chk(irq, 0, "R3 both empty");

        // R7 truncation
        send(130, 3, 1);
        chk(rx_ovf, 1, "R7 ovf");
        drain(128, 128);
        send(3, 200, 1);
        chk(rx_ovf, 0, "R7 ovf cleared");
        drain(3, 3);

        // R8 abort
        @(negedge clk); rx_sop = 1;
        @(negedge clk); rx_sop = 0; rx_valid = 1; rx_data = 8'h55;
        repeat (3) @(negedge clk);
        rx_valid = 0; rx_abort = 1;
        @(negedge clk); rx_abort = 0;
        @(negedge clk);
        chk(irq, 0, "R8 irq"); chk(rd_valid, 0, "R8 empty");
        send(3, 77, 1);
        drain(3, 3);

        // R9 zero-length
        send(0, 0, 0);
        @(negedge clk);
        chk(irq, 0, "R9 irq"); chk(rd_valid, 0, "R9 valid");

        // R10 stray reads
        rd_en = 1;
        repeat (4) @(negedge clk);
        chk(rd_data, 0, "R10 data");
        rd_en = 0;
        send(4, 120, 1);
        drain(4, 4);

        // R11 packet while full is ignored
        send(5, 10, 1);
        send(7, 60, 1);
        send(9, 150, 0);
        drain(5, 5);
        drain(7, 7);
        @(negedge clk);
        chk(rd_valid, 0, "R11 nothing extra");
        chk(exp_q.size(), 0, "R11 scoreboard empty");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule